// File: doc/BRIEF.md
# Page-Based Access Guard with Requester ID Remap

This block sits in front of a local memory region that is divided into equal pages. It checks every access from two request ports: a local processor port and a remote port used by system masters such as DMA engines. Each page has one permission word. A local access is judged only on its privilege mode (user or supervisor) and its direction (read or write). A remote access also carries a 4-bit privilege ID. A programmable table remaps that ID to a 3-bit allowed ID, and the allowed ID must also be enabled in the page's permission word.

The allow/deny decision is combinational and comes in the same cycle as the request. A denied write never reaches the memory, and a denied read returns zero. The first violation is latched together with its address, its access type and, for a remote access, its privilege ID. One cycle later a one-cycle exception pulse is raised on the output for the port that caused the violation. Later violations are still blocked but are not recorded until software writes the clear bit.

A small word-indexed register interface programs the page permissions and the remap table, reads back the fault record, and clears it.

Top module: `page_guard`

## Requirements
- R1: After reset, every page permission word reads 0x0000FF0F, which allows every access. The fault address and fault info registers read 0, and both exception outputs are low.
- R2: After reset, remap entry p (register 16+p) reads back its default value. Privilege IDs 0, 1, 2 and 3 map to allowed IDs 0, 1, 2 and 3. ID 6 maps to 4, ID 9 maps to 5, and every other ID maps to the catch-all value 7.
- R3: A remote access is granted only when two bits of the page word are set: the mode/direction bit (bit 0 user read, bit 1 user write, bit 2 supervisor read, bit 3 supervisor write) and the bit 8+A, where A is the allowed ID the remap table gives for the request's privilege ID.
- R4: A local access is granted when its mode/direction bit (same positions as R3) is set. Bits 15:8 of the page word are ignored for local accesses.
- R5: The grant output is valid in the same cycle as the request. The memory write enable for a port is high only for a granted write. The read data output for a port is the memory data for a granted read and zero otherwise.
- R6: The page of an access is given by the address bits above the page offset (address bits 15:12 with the defaults). The permissions of that page alone apply.
- R7: When no fault is held, the first denied access latches three things. Register 32 receives its address. Register 33 receives the fault info: bit 0 valid, bit 1 remote, bit 2 write, bit 3 supervisor, bits 7:4 privilege ID (0 for local). While a fault is held, later violations leave both registers unchanged.
- R8: A newly latched fault raises a pulse lasting exactly one cycle, on the cycle after the violating request. The local port's fault pulses exc_local and the remote port's fault pulses exc_remote. If both ports violate in the same cycle, the local one is recorded and only exc_local pulses.
- R9: Writing bit 0 of register 34 clears the held fault. Writing register 16+p changes the allowed ID used for privilege ID p on the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| loc_req | input | 1 | Local access valid |
| loc_we | input | 1 | Local access is a write |
| loc_sup | input | 1 | Local access in supervisor mode |
| loc_addr | input | 16 | Local access byte address |
| loc_mem_rdata | input | 32 | Read data from memory for the local port |
| loc_grant | output | 1 | Local access allowed |
| loc_mem_we | output | 1 | Gated memory write enable for the local port |
| loc_rdata | output | 32 | Gated read data to the local requester |
| rem_req | input | 1 | Remote access valid |
| rem_we | input | 1 | Remote access is a write |
| rem_sup | input | 1 | Remote access in supervisor mode |
| rem_pid | input | 4 | Remote privilege ID |
| rem_addr | input | 16 | Remote access byte address |
| rem_mem_rdata | input | 32 | Read data from memory for the remote port |
| rem_grant | output | 1 | Remote access allowed |
| rem_mem_we | output | 1 | Gated memory write enable for the remote port |
| rem_rdata | output | 32 | Gated read data to the remote requester |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register word index (0-15 pages, 16-31 remap, 32 fault address, 33 fault info, 34 control) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| exc_local | output | 1 | One-cycle exception for a local violation |
| exc_remote | output | 1 | One-cycle exception for a remote violation |

## Verification
The hardest case to reach is two violations in the same cycle, one from each port, while no fault is held. The bench first clears any leftover fault through the control register. It then drives a denied local write and a denied remote read in the same clock, and checks that exc_local pulses alone and that the recorded address and info are the local ones. The hold behaviour is reached in a similar way: one violation is latched, and a second violation from the other port is made before the clear.

// File: rtl/pg_pkg.sv
package pg_pkg;

  localparam int PID_W     = 4;
  localparam int NPID      = 1 << PID_W;
  localparam int AID_W     = 3;
  localparam int AID_BASE  = 8;
  localparam logic [AID_W-1:0] AID_CATCH = 3'd7;

  localparam logic [31:0] PERM_MASK = 32'h0000_FF0F;
  localparam logic [31:0] PERM_OPEN = 32'h0000_FF0F;

  // Default privilege-ID to allowed-ID mapping.
  function automatic logic [AID_W-1:0] default_aid(input logic [PID_W-1:0] pid);
    logic [AID_W-1:0] a;
    case (pid)
      4'd0, 4'd1, 4'd2, 4'd3: a = pid[AID_W-1:0];
      4'd6:                   a = 3'd4;
      4'd9:                   a = 3'd5;
      default:                a = AID_CATCH;
    endcase
    return a;
  endfunction

  // Mode/direction enable: bit index = {supervisor, write}.
  function automatic logic mode_ok(input logic [31:0] perm, input logic we, input logic sup);
    logic [1:0] sel;
    sel = {sup, we};
    return perm[sel];
  endfunction

  function automatic logic id_ok(input logic [31:0] perm, input logic [AID_W-1:0] aid);
    return perm[AID_BASE + int'(aid)];
  endfunction

endpackage

// File: rtl/pg_remap.sv
module pg_remap
  import pg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PID_W-1:0] idx,
  input  logic [AID_W-1:0] wr_val,
  output logic [AID_W-1:0] rd_val,
  input  logic [PID_W-1:0] pid_in,
  output logic [AID_W-1:0] aid_out
);

  logic [AID_W-1:0] tbl [NPID];

  for (genvar i = 0; i < NPID; i++) begin : g_ent
    logic [AID_W-1:0] ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent <= default_aid(PID_W'(i));
      else if (wr_en && idx == PID_W'(i))
        ent <= wr_val;
    end
    assign tbl[i] = ent;
  end

  assign rd_val  = tbl[idx];
  assign aid_out = tbl[pid_in];

  // R9: a written entry holds the written value afterwards
  p_remap_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_val == $past(wr_val)) || (idx != $past(idx)));

endmodule

// File: rtl/pg_perm.sv
module pg_perm
  import pg_pkg::*;
#(
  parameter int NPAGES = 16,
  localparam int PIDX_W = $clog2(NPAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] idx,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [PIDX_W-1:0] loc_pg,
  output logic [31:0]       loc_perm,
  input  logic [PIDX_W-1:0] rem_pg,
  output logic [31:0]       rem_perm
);

  logic [31:0] words [NPAGES];

  for (genvar i = 0; i < NPAGES; i++) begin : g_page
    logic [31:0] w;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        w <= PERM_OPEN;
      else if (wr_en && idx == PIDX_W'(i))
        w <= wr_data & PERM_MASK;
    end
    assign words[i] = w;
  end

  assign rd_data  = words[idx];
  assign loc_perm = words[loc_pg];
  assign rem_perm = words[rem_pg];

  // R1: reserved bits never become set
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~PERM_MASK) == 32'h0);

endmodule

// File: rtl/pg_fault.sv
module pg_fault
  import pg_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             loc_viol,
  input  logic             loc_we,
  input  logic             loc_sup,
  input  logic [AW-1:0]    loc_addr,
  input  logic             rem_viol,
  input  logic             rem_we,
  input  logic             rem_sup,
  input  logic [PID_W-1:0] rem_pid,
  input  logic [AW-1:0]    rem_addr,
  output logic             valid,
  output logic [AW-1:0]    f_addr,
  output logic [7:0]       f_info,
  output logic             exc_loc,
  output logic             exc_rem
);

  logic             f_remote, f_we, f_sup;
  logic [PID_W-1:0] f_pid;
  logic             capture;

  assign capture = !clr && !valid && (loc_viol || rem_viol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      f_addr   <= '0;
      f_remote <= 1'b0;
      f_we     <= 1'b0;
      f_sup    <= 1'b0;
      f_pid    <= '0;
      exc_loc  <= 1'b0;
      exc_rem  <= 1'b0;
    end else begin
      exc_loc <= 1'b0;
      exc_rem <= 1'b0;
      if (clr) begin
        valid    <= 1'b0;
        f_addr   <= '0;
        f_remote <= 1'b0;
        f_we     <= 1'b0;
        f_sup    <= 1'b0;
        f_pid    <= '0;
      end else if (capture) begin
        valid <= 1'b1;
        if (loc_viol) begin
          f_addr   <= loc_addr;
          f_remote <= 1'b0;
          f_we     <= loc_we;
          f_sup    <= loc_sup;
          f_pid    <= '0;
          exc_loc  <= 1'b1;
        end else begin
          f_addr   <= rem_addr;
          f_remote <= 1'b1;
          f_we     <= rem_we;
          f_sup    <= rem_sup;
          f_pid    <= rem_pid;
          exc_rem  <= 1'b1;
        end
      end
    end
  end

  assign f_info = {f_pid, f_sup, f_we, f_remote, valid};

  // R8: exceptions last one cycle and never coincide
  p_exc_loc_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_loc |=> !exc_loc);
  p_exc_rem_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_rem |=> !exc_rem);
  p_exc_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_loc && exc_rem));
  // R7: a held fault keeps its record until cleared
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !clr) |=> (valid && $stable(f_addr) && $stable(f_pid)));
  // R7/R8: a first violation is latched and signalled
  p_first_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !clr && (loc_viol || rem_viol)) |=> (valid && (exc_loc || exc_rem)));
  // R8: local wins a simultaneous violation
  p_local_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !clr && loc_viol) |=> exc_loc);

endmodule

// File: rtl/page_guard.sv
module page_guard
  import pg_pkg::*;
#(
  parameter int NPAGES     = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int DW         = 32,
  parameter int CFG_AW     = 6,
  localparam int PAGE_BITS = $clog2(PAGE_BYTES),
  localparam int PIDX_W    = $clog2(NPAGES),
  localparam int AW        = PAGE_BITS + PIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_req,
  input  logic              loc_we,
  input  logic              loc_sup,
  input  logic [AW-1:0]     loc_addr,
  input  logic [DW-1:0]     loc_mem_rdata,
  output logic              loc_grant,
  output logic              loc_mem_we,
  output logic [DW-1:0]     loc_rdata,
  input  logic              rem_req,
  input  logic              rem_we,
  input  logic              rem_sup,
  input  logic [PID_W-1:0]  rem_pid,
  input  logic [AW-1:0]     rem_addr,
  input  logic [DW-1:0]     rem_mem_rdata,
  output logic              rem_grant,
  output logic              rem_mem_we,
  output logic [DW-1:0]     rem_rdata,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              exc_local,
  output logic              exc_remote
);

  localparam logic [CFG_AW-1:0] REMAP_BASE = CFG_AW'(NPAGES);
  localparam logic [CFG_AW-1:0] FADDR_IDX  = CFG_AW'(NPAGES + NPID);
  localparam logic [CFG_AW-1:0] FINFO_IDX  = CFG_AW'(NPAGES + NPID + 1);
  localparam logic [CFG_AW-1:0] CTRL_IDX   = CFG_AW'(NPAGES + NPID + 2);

  // Configuration decode
  logic perm_sel, remap_sel, clr;
  logic [PID_W-1:0] remap_idx;
  assign perm_sel  = cfg_addr < REMAP_BASE;
  assign remap_sel = !perm_sel && (cfg_addr < FADDR_IDX);
  assign remap_idx = cfg_addr[PID_W-1:0] - REMAP_BASE[PID_W-1:0];
  assign clr       = cfg_we && (cfg_addr == CTRL_IDX) && cfg_wdata[0];

  // Page lookup
  logic [PIDX_W-1:0] loc_pg, rem_pg;
  logic [31:0]       loc_perm, rem_perm, perm_rd;
  assign loc_pg = loc_addr[AW-1:PAGE_BITS];
  assign rem_pg = rem_addr[AW-1:PAGE_BITS];

  pg_perm #(.NPAGES(NPAGES)) u_perm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we && perm_sel),
    .idx      (cfg_addr[PIDX_W-1:0]),
    .wr_data  (cfg_wdata),
    .rd_data  (perm_rd),
    .loc_pg   (loc_pg),
    .loc_perm (loc_perm),
    .rem_pg   (rem_pg),
    .rem_perm (rem_perm)
  );

  logic [AID_W-1:0] rem_aid, remap_rd;

  pg_remap u_remap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we && remap_sel),
    .idx     (remap_idx),
    .wr_val  (cfg_wdata[AID_W-1:0]),
    .rd_val  (remap_rd),
    .pid_in  (rem_pid),
    .aid_out (rem_aid)
  );

  // Same-cycle decisions
  logic loc_viol, rem_viol;
  assign loc_grant  = loc_req && mode_ok(loc_perm, loc_we, loc_sup);
  assign rem_grant  = rem_req && mode_ok(rem_perm, rem_we, rem_sup) && id_ok(rem_perm, rem_aid);
  assign loc_viol   = loc_req && !loc_grant;
  assign rem_viol   = rem_req && !rem_grant;
  assign loc_mem_we = loc_grant && loc_we;
  assign rem_mem_we = rem_grant && rem_we;
  assign loc_rdata  = (loc_grant && !loc_we) ? loc_mem_rdata : '0;
  assign rem_rdata  = (rem_grant && !rem_we) ? rem_mem_rdata : '0;

  logic          f_valid;
  logic [AW-1:0] f_addr;
  logic [7:0]    f_info;

  pg_fault #(.AW(AW)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .loc_viol (loc_viol),
    .loc_we   (loc_we),
    .loc_sup  (loc_sup),
    .loc_addr (loc_addr),
    .rem_viol (rem_viol),
    .rem_we   (rem_we),
    .rem_sup  (rem_sup),
    .rem_pid  (rem_pid),
    .rem_addr (rem_addr),
    .valid    (f_valid),
    .f_addr   (f_addr),
    .f_info   (f_info),
    .exc_loc  (exc_local),
    .exc_rem  (exc_remote)
  );

  always_comb begin
    cfg_rdata = '0;
    if (perm_sel)                    cfg_rdata = perm_rd;
    else if (remap_sel)              cfg_rdata = {{(32-AID_W){1'b0}}, remap_rd};
    else if (cfg_addr == FADDR_IDX)  cfg_rdata = {{(32-AW){1'b0}}, f_addr};
    else if (cfg_addr == FINFO_IDX)  cfg_rdata = {24'h0, f_info};
  end

  // R5: denied reads see zero, denied writes do not reach memory
  p_loc_deny_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loc_viol |-> (loc_rdata == '0 && !loc_mem_we));
  p_rem_deny_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rem_viol |-> (rem_rdata == '0 && !rem_mem_we));
  // R7: fault valid bit agrees with a non-empty record
  p_valid_info_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_local || exc_remote) |-> f_valid);

endmodule

// File: tb/sim_page_guard.sv
`timescale 1ns/1ps
module sim_page_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loc_req = 0, loc_we = 0, loc_sup = 0;
  logic [15:0] loc_addr = '0;
  logic [31:0] loc_mem_rdata = 32'hA5A5_0001;
  logic        loc_grant, loc_mem_we;
  logic [31:0] loc_rdata;
  logic        rem_req = 0, rem_we = 0, rem_sup = 0;
  logic [3:0]  rem_pid = '0;
  logic [15:0] rem_addr = '0;
  logic [31:0] rem_mem_rdata = 32'h5A5A_0002;
  logic        rem_grant, rem_mem_we;
  logic [31:0] rem_rdata;
  logic        cfg_we = 0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        exc_local, exc_remote;

  always #10 clk = ~clk;

  page_guard u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Captured results of the last access
  logic s_lg, s_lwe, s_rg, s_rwe;
  logic [31:0] s_lrd, s_rrd;
  logic s_el1, s_er1, s_el2, s_er2;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_aid(input int pid);
    if (pid < 4) return 3'(pid);
    if (pid == 6) return 3'd4;
    if (pid == 9) return 3'd5;
    return 3'd7;
  endfunction

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic clear_fault();
    cfg_write(6'd34, 32'h1);
  endtask

  task automatic access(input logic lq, input logic lw, input logic ls, input logic [15:0] la,
                        input logic rq, input logic rw, input logic rs, input logic [3:0] rp,
                        input logic [15:0] ra);
    @(negedge clk);
    loc_req = lq; loc_we = lw; loc_sup = ls; loc_addr = la;
    rem_req = rq; rem_we = rw; rem_sup = rs; rem_pid = rp; rem_addr = ra;
    #1;
    s_lg = loc_grant; s_lwe = loc_mem_we; s_lrd = loc_rdata;
    s_rg = rem_grant; s_rwe = rem_mem_we; s_rrd = rem_rdata;
    @(negedge clk);
    s_el1 = exc_local; s_er1 = exc_remote;
    loc_req = 0; rem_req = 0;
    @(negedge clk);
    s_el2 = exc_local; s_er2 = exc_remote;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int p = 0; p < 16; p++) begin
      cfg_read(6'(p), d);
      chk("R1", $sformatf("page %0d word", p), d, 32'h0000_FF0F);
    end
    for (int p = 0; p < 16; p++) begin
      cfg_read(6'(16 + p), d);
      chk("R2", $sformatf("remap %0d", p), d, {29'h0, ref_aid(p)});
    end
    cfg_read(6'd32, d); chk("R1", "fault addr", d, 32'h0);
    cfg_read(6'd33, d); chk("R1", "fault info", d, 32'h0);
    chk("R1", "exc_local", {31'h0, exc_local}, 32'h0);
    chk("R1", "exc_remote", {31'h0, exc_remote}, 32'h0);
    access(1, 1, 0, 16'h0040, 1, 1, 0, 4'd11, 16'hF000);
    chk("R1", "open local write", {31'h0, s_lwe}, 32'h1);
    chk("R1", "open remote write", {31'h0, s_rwe}, 32'h1);
  endtask

  task automatic t_local();
    cfg_write(6'd3, 32'h0000_0001);   // page 3: user read only, no ID bits
    clear_fault();
    access(1, 0, 0, 16'h3010, 0, 0, 0, 0, 0);
    chk("R4", "local user read grant", {31'h0, s_lg}, 32'h1);
    chk("R5", "local read data", s_lrd, 32'hA5A5_0001);
    access(1, 1, 0, 16'h3014, 0, 0, 0, 0, 0);
    chk("R4", "local user write grant", {31'h0, s_lg}, 32'h0);
    chk("R5", "local denied write enable", {31'h0, s_lwe}, 32'h0);
    access(1, 0, 1, 16'h3018, 0, 0, 0, 0, 0);
    chk("R4", "local sup read grant", {31'h0, s_lg}, 32'h0);
    chk("R5", "local denied read data", s_lrd, 32'h0);
    clear_fault();
  endtask

  task automatic t_remote();
    cfg_write(6'd5, 32'h0000_200C);   // page 5: sup read/write, allowed ID 5
    access(0, 0, 0, 0, 1, 1, 1, 4'd9, 16'h5004);
    chk("R3", "pid9 sup write grant", {31'h0, s_rg}, 32'h1);
    chk("R5", "pid9 sup write enable", {31'h0, s_rwe}, 32'h1);
    access(0, 0, 0, 0, 1, 1, 1, 4'd6, 16'h5004);
    chk("R3", "pid6 sup write grant", {31'h0, s_rg}, 32'h0);
    chk("R5", "pid6 denied write enable", {31'h0, s_rwe}, 32'h0);
    access(0, 0, 0, 0, 1, 0, 0, 4'd9, 16'h5008);
    chk("R3", "pid9 user read grant", {31'h0, s_rg}, 32'h0);
    chk("R5", "pid9 denied read data", s_rrd, 32'h0);
    clear_fault();
    access(0, 0, 0, 0, 1, 0, 1, 4'd9, 16'h5008);
    chk("R5", "pid9 sup read data", s_rrd, 32'h5A5A_0002);
    chk("R9", "no fault on granted access", {31'h0, s_er1}, 32'h0);
  endtask

  task automatic t_page();
    access(0, 0, 0, 0, 1, 0, 0, 4'd6, 16'h6000);
    chk("R6", "page 6 first byte grant", {31'h0, s_rg}, 32'h1);
    access(0, 0, 0, 0, 1, 0, 0, 4'd6, 16'h5FFF);
    chk("R6", "page 5 last byte grant", {31'h0, s_rg}, 32'h0);
    clear_fault();
  endtask

  task automatic t_fault();
    logic [31:0] d;
    clear_fault();
    access(0, 0, 0, 0, 1, 1, 0, 4'd2, 16'h5ABC);
    chk("R8", "exc_remote pulse", {31'h0, s_er1}, 32'h1);
    chk("R8", "exc_local quiet", {31'h0, s_el1}, 32'h0);
    chk("R8", "exc_remote one cycle", {31'h0, s_er2}, 32'h0);
    cfg_read(6'd32, d); chk("R7", "remote fault addr", d, 32'h0000_5ABC);
    cfg_read(6'd33, d); chk("R7", "remote fault info", d, 32'h0000_0027);
    access(1, 1, 0, 16'h3000, 0, 0, 0, 0, 0);
    chk("R7", "second fault no exc", {31'h0, s_el1}, 32'h0);
    cfg_read(6'd32, d); chk("R7", "addr held", d, 32'h0000_5ABC);
    cfg_read(6'd33, d); chk("R7", "info held", d, 32'h0000_0027);
    clear_fault();
    cfg_read(6'd33, d); chk("R9", "info cleared", d, 32'h0);
    access(1, 0, 1, 16'h3008, 0, 0, 0, 0, 0);
    chk("R8", "exc_local pulse", {31'h0, s_el1}, 32'h1);
    chk("R8", "exc_local one cycle", {31'h0, s_el2}, 32'h0);
    cfg_read(6'd32, d); chk("R7", "local fault addr", d, 32'h0000_3008);
    cfg_read(6'd33, d); chk("R7", "local fault info", d, 32'h0000_0009);
  endtask

  task automatic t_both();
    logic [31:0] d;
    clear_fault();
    access(1, 1, 0, 16'h3100, 1, 0, 0, 4'd0, 16'h5200);
    chk("R8", "simultaneous exc_local", {31'h0, s_el1}, 32'h1);
    chk("R8", "simultaneous exc_remote", {31'h0, s_er1}, 32'h0);
    cfg_read(6'd32, d); chk("R8", "simultaneous addr", d, 32'h0000_3100);
    cfg_read(6'd33, d); chk("R8", "simultaneous info", d, 32'h0000_0005);
  endtask

  task automatic t_remap();
    logic [31:0] d;
    clear_fault();
    access(0, 0, 0, 0, 1, 1, 1, 4'd12, 16'h5010);
    chk("R9", "pid12 before remap", {31'h0, s_rg}, 32'h0);
    cfg_write(6'd28, 32'h5);
    cfg_read(6'd28, d); chk("R9", "remap 12 readback", d, 32'h5);
    access(0, 0, 0, 0, 1, 1, 1, 4'd12, 16'h5010);
    chk("R9", "pid12 after remap", {31'h0, s_rg}, 32'h1);
    clear_fault();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_local();
    t_remote();
    t_page();
    t_fault();
    t_both();
    t_remap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule